// File: doc/BRIEF.md
# Cell Routing Demultiplexer FIFO

This block takes fixed-length cells from a single input stream and copies each whole cell into one or more of four output queues. Each queue stores 9-bit words and has its own output stream. Three static configuration pins select the routing. One pin sets the input width to 9 or 18 bits. A second pin chooses single-destination or multi-destination steering. A third pin decides whether the destination comes from a sideband address bus or from the low bits of the cell's first word.

The destination is decided once, on the start-of-cell beat, and the cell's later beats follow that decision. A cell is admitted only when every queue it targets can hold the entire cell. Otherwise the whole cell is consumed and discarded, and a drop flag pulses. Each output queue marks the first word of every cell it delivers.

The input stream is valid/ready. A beat transfers on a rising edge where `in_valid` and `in_ready` are both high. In 9-bit mode `in_ready` is always high, and cells the block cannot store are dropped rather than stalled. In 18-bit mode `in_ready` falls for exactly one cycle after each accepted beat inside a cell, while the upper word is written. Each output is valid/ready. A word is removed on an edge where `out_valid` and `out_ready` are both high. While it waits, the word is held unchanged.

Top module: `cell_demux_fifo`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, every `out_valid` bit is 0, `in_ready` is 1 and `cell_drop` is 0. Reset clears all queue storage, all pointers and any partly received cell.
- R2: Singlecast, out-band routing (`cfg_mcast`=0, `cfg_inband`=0): if `in_dest` is 0 to 3 on the start beat, all CELL_WORDS words of the cell appear in order on queue `in_dest` only.
- R3: In singlecast mode, a destination value of 4 to 31 discards the cell. No queue receives any of its words, and `cell_drop` pulses.
- R4: Multicast (`cfg_mcast`=1): destination bit k (k = 0..3) enables queue k, and each enabled queue gets its own full copy of the cell. Bit 4 is ignored. An all-zero enable set discards the cell and pulses `cell_drop`.
- R5: In-band routing (`cfg_inband`=1): the destination is taken from `in_data[4:0]` of the start beat, and `in_dest` is ignored. The first word is still stored as part of the cell.
- R6: With `cfg_narrow`=0, each beat carries two words. `in_data[8:0]` is stored first, then `in_data[17:9]`. `in_ready` is 0 in the cycle after each accepted beat of a cell. With `cfg_narrow`=1, only `in_data[8:0]` is used.
- R7: The destination is latched on the start beat. Changes to `in_dest` on later beats of the same cell have no effect.
- R8: If any targeted queue has fewer than CELL_WORDS free entries on the start beat, the whole cell is dropped and no queue receives any of it. `cell_drop` is high for exactly the one cycle after the start beat.
- R9: `out_soc[q]` is 1 exactly when queue q presents the first word of a cell.
- R10: A presented word stays valid and unchanged until it is taken. Words leave each queue in arrival order, and a written word is presented no earlier than the cycle after its write edge.
- R11: A beat with `in_sop`=0 that arrives outside a cell is discarded. `in_sop` on a beat inside a cell is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_narrow | input | 1 | 1: 9-bit input words, 0: two words per beat |
| cfg_mcast | input | 1 | 1: destination is a per-queue enable set |
| cfg_inband | input | 1 | 1: destination taken from the first data word |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat can be accepted |
| in_sop | input | 1 | Beat starts a cell |
| in_data | input | 18 | Input data, low word in [8:0] |
| in_dest | input | 5 | Sideband destination, sampled on the start beat |
| out_valid | output | 4 | Per-queue word valid |
| out_ready | input | 4 | Per-queue word taken |
| out_soc | output | 4 | Per-queue first word of a cell |
| out_data | output | 36 | Queue q word in bits [9q+8:9q] |
| cell_drop | output | 1 | One-cycle pulse for a discarded cell |

## Verification
A word written on edge E makes its queue's `out_valid` rise in the cycle after E. `cell_drop` is high in the cycle that follows the edge taking the start beat. In 18-bit mode, `in_ready` is low in the cycle after each accepted beat. The bench drives inputs 2 ns after a rising edge. It reads `cell_drop` and `in_ready` at that point, right after the beat's edge. The scoreboard monitor takes output words at the falling edge, so every output sample falls within the cycle where the result is due.

// File: rtl/cdf_pkg.sv
package cdf_pkg;
  localparam int NQ = 4;
  localparam int WW = 9;
  localparam int AW = 5;

  typedef logic [NQ-1:0] qmask_t;
  typedef logic [WW-1:0] word_t;

  // Turn a destination field into a per-queue select mask.
  function automatic qmask_t dest_to_mask(input logic mcast, input logic [AW-1:0] sel);
    qmask_t m;
    m = '0;
    if (mcast)
      m = sel[NQ-1:0];
    else if (sel < AW'(NQ))
      m = qmask_t'(1) << sel;
    return m;
  endfunction
endpackage

// File: rtl/cdf_route.sv
module cdf_route
  import cdf_pkg::*;
(
  input  logic          mcast,
  input  logic          inband,
  input  logic [AW-1:0] side_dest,
  input  logic [AW-1:0] hdr_dest,
  output qmask_t        mask
);
  always_comb mask = dest_to_mask(mcast, inband ? hdr_dest : side_dest);
endmodule

// File: rtl/cdf_steer.sv
module cdf_steer
  import cdf_pkg::*;
#(
  parameter int CELL_WORDS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              narrow,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_sop,
  input  logic [2*WW-1:0]   in_data,
  input  qmask_t            dest_mask,
  input  qmask_t            room_ok,
  output logic              busy,
  output qmask_t            wr_mask,
  output word_t             wr_word,
  output logic              drop
);
  localparam int CNTW = $clog2(CELL_WORDS);

  logic            hold_pend;
  word_t           hold_word;
  logic            keep;
  qmask_t          cur_mask;
  logic [CNTW-1:0] cnt;

  logic fire, start, cell_beat, slot, admit, last;

  assign in_ready  = ~hold_pend;
  assign fire      = in_valid & in_ready;
  assign start     = fire & ~busy & in_sop;
  assign cell_beat = fire & busy;
  assign slot      = start | cell_beat | hold_pend;
  assign admit     = (dest_mask != '0) && ((dest_mask & ~room_ok) == '0);
  assign last      = (cnt == CNTW'(CELL_WORDS - 1));

  always_comb begin
    wr_mask = '0;
    wr_word = in_data[WW-1:0];
    if (hold_pend) begin
      wr_word = hold_word;
      wr_mask = keep ? cur_mask : '0;
    end else if (start) begin
      wr_mask = admit ? dest_mask : '0;
    end else if (cell_beat) begin
      wr_mask = keep ? cur_mask : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_pend <= 1'b0;
      hold_word <= '0;
      keep      <= 1'b0;
      cur_mask  <= '0;
      cnt       <= '0;
      busy      <= 1'b0;
      drop      <= 1'b0;
    end else begin
      drop      <= start & ~admit;
      hold_pend <= ~narrow & (start | cell_beat);
      if (start | cell_beat)
        hold_word <= in_data[2*WW-1:WW];
      if (start) begin
        cur_mask <= dest_mask;
        keep     <= admit;
      end
      if (slot) begin
        if (last) begin
          cnt  <= '0;
          busy <= 1'b0;
        end else begin
          cnt  <= cnt + 1'b1;
          busy <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/cdf_queue.sv
module cdf_queue
  import cdf_pkg::*;
#(
  parameter int DEPTH      = 128,
  parameter int CELL_WORDS = 8
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  push,
  input  word_t push_word,
  input  logic  pop_ready,
  output logic  out_valid,
  output word_t out_word,
  output logic  out_soc,
  output logic  room_ok
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int SW = $clog2(CELL_WORDS);

  word_t         mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count, free_w;
  logic [SW-1:0] rd_pos;
  logic          pop;

  assign pop       = out_valid & pop_ready;
  assign out_valid = (count != '0);
  assign out_word  = mem[rd_ptr];
  assign out_soc   = (rd_pos == '0);
  assign free_w    = CW'(DEPTH) - count;
  assign room_ok   = (free_w >= CW'(CELL_WORDS));

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      rd_pos <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (push) begin
        mem[wr_ptr] <= push_word;
        wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      end
      if (pop) begin
        rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
        rd_pos <= (rd_pos == SW'(CELL_WORDS - 1)) ? '0 : rd_pos + 1'b1;
      end
      count <= count + CW'(push) - CW'(pop);
    end
  end
endmodule

// File: rtl/cell_demux_fifo.sv
module cell_demux_fifo
  import cdf_pkg::*;
#(
  parameter int CELL_WORDS = 8,
  parameter int DEPTH      = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_narrow,
  input  logic             cfg_mcast,
  input  logic             cfg_inband,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_sop,
  input  logic [2*WW-1:0]  in_data,
  input  logic [AW-1:0]    in_dest,
  output logic [NQ-1:0]    out_valid,
  input  logic [NQ-1:0]    out_ready,
  output logic [NQ-1:0]    out_soc,
  output logic [NQ*WW-1:0] out_data,
  output logic             cell_drop
);
  qmask_t dest_mask, room_ok, wr_mask;
  word_t  wr_word;
  logic   cell_busy;

  cdf_route u_route (
    .mask(dest_mask), .mcast(cfg_mcast), .inband(cfg_inband),
    .side_dest(in_dest), .hdr_dest(in_data[AW-1:0])
  );

  cdf_steer #(.CELL_WORDS(CELL_WORDS)) u_steer (
    .clk(clk), .rst(rst), .narrow(cfg_narrow),
    .in_valid(in_valid), .in_ready(in_ready), .in_sop(in_sop), .in_data(in_data),
    .dest_mask(dest_mask), .room_ok(room_ok), .busy(cell_busy),
    .wr_mask(wr_mask), .wr_word(wr_word), .drop(cell_drop)
  );

  for (genvar q = 0; q < NQ; q++) begin : g_queue
    cdf_queue #(.DEPTH(DEPTH), .CELL_WORDS(CELL_WORDS)) u_q (
      .clk(clk), .rst(rst), .push(wr_mask[q]), .push_word(wr_word),
      .pop_ready(out_ready[q]), .out_valid(out_valid[q]),
      .out_word(out_data[q*WW +: WW]), .out_soc(out_soc[q]), .room_ok(room_ok[q])
    );
  end
endmodule

// File: rtl/cdf_props.sv
module cdf_props
  import cdf_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             narrow,
  input logic             in_valid,
  input logic             in_ready,
  input logic             in_sop,
  input logic             busy,
  input qmask_t           wr_mask,
  input logic             cell_drop,
  input logic [NQ-1:0]    out_valid,
  input logic [NQ-1:0]    out_ready,
  input logic [NQ*WW-1:0] out_data
);
  // R6
  wide_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && !narrow && (busy || in_sop)) |=> !in_ready);

  // R8
  drop_single_chk: assert property (@(posedge clk) disable iff (rst)
    cell_drop |=> !cell_drop);

  // R3
  drop_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
    cell_drop |-> ($past(wr_mask) == '0));

  // R11
  stray_beat_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && !busy && !in_sop) |-> (wr_mask == '0));

  for (genvar q = 0; q < NQ; q++) begin : g_hold
    // R10
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
      (out_valid[q] && !out_ready[q]) |=> (out_valid[q] && $stable(out_data[q*WW +: WW])));
  end
endmodule

bind cell_demux_fifo cdf_props u_props (
  .clk(clk), .rst(rst), .narrow(cfg_narrow), .in_valid(in_valid),
  .in_ready(in_ready), .in_sop(in_sop), .busy(cell_busy), .wr_mask(wr_mask),
  .cell_drop(cell_drop), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data)
);

// File: tb/sim_cell_demux_fifo.sv
module sim_cell_demux_fifo;
  localparam int CLK_PERIOD = 10;
  localparam int CELL  = 8;
  localparam int DEPTH = 128;

  logic        clk = 0, rst = 1;
  logic        cfg_narrow = 1, cfg_mcast = 0, cfg_inband = 0;
  logic        in_valid = 0, in_sop = 0;
  logic [17:0] in_data = '0;
  logic [4:0]  in_dest = '0;
  logic        in_ready, cell_drop;
  logic [3:0]  out_valid, out_soc, out_ready = '1;
  logic [35:0] out_data;

  cell_demux_fifo #(.CELL_WORDS(CELL), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst(rst), .cfg_narrow(cfg_narrow), .cfg_mcast(cfg_mcast),
    .cfg_inband(cfg_inband), .in_valid(in_valid), .in_ready(in_ready),
    .in_sop(in_sop), .in_data(in_data), .in_dest(in_dest),
    .out_valid(out_valid), .out_ready(out_ready), .out_soc(out_soc),
    .out_data(out_data), .cell_drop(cell_drop)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int vectors = 0, fails = 0;
  logic [9:0] expq [4][$];
  logic [8:0] cw [CELL];
  bit stall_on = 0, hold_all = 0;
  int tick = 0;

  function automatic void check(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endfunction

  // Output-ready pattern generator.
  always begin
    @(posedge clk); #2;
    tick++;
    for (int q = 0; q < 4; q++)
      out_ready[q] = hold_all ? 1'b0 : (stall_on ? (((tick + q) % 3) != 0) : 1'b1);
  end

  // Scoreboard monitor.
  logic [3:0] prev_stall = '0;
  logic [8:0] prev_word [4];
  always @(negedge clk) begin
    if (!rst) begin
      for (int q = 0; q < 4; q++) begin
        if (prev_stall[q])
          check($sformatf("R10 hold q%0d", q), {out_valid[q], out_data[q*9 +: 9]}, {1'b1, prev_word[q]});
        if (out_valid[q] && out_ready[q]) begin
          if (expq[q].size() == 0)
            check($sformatf("R3 R11 unexpected q%0d", q), {out_soc[q], out_data[q*9 +: 9]}, 32'hFFFF);
          else
            check($sformatf("R2 R9 data q%0d", q), {out_soc[q], out_data[q*9 +: 9]}, expq[q].pop_front());
        end
        prev_stall[q] = out_valid[q] && !out_ready[q];
        prev_word[q]  = out_data[q*9 +: 9];
      end
    end else prev_stall = '0;
  end

  task automatic beat(input logic sop, input logic [17:0] d, input logic [4:0] a);
    in_valid = 1; in_sop = sop; in_data = d; in_dest = a;
    do @(negedge clk); while (!in_ready);
    @(posedge clk); #2;
    in_valid = 0; in_sop = 0;
  endtask

  task automatic mk(input int base);
    for (int i = 0; i < CELL; i++) cw[i] = 9'(base + i * 7);
  endtask

  task automatic send_cell(input string req, input logic [4:0] a, input logic [4:0] a_late,
                           input logic [3:0] mask, input bit mid_sop);
    bit ok;
    ok = (mask != 0);
    for (int q = 0; q < 4; q++)
      if (mask[q] && expq[q].size() + CELL > DEPTH) ok = 0;
    if (ok)
      for (int q = 0; q < 4; q++)
        if (mask[q])
          for (int i = 0; i < CELL; i++) expq[q].push_back({i == 0, cw[i]});
    if (cfg_narrow) begin
      for (int i = 0; i < CELL; i++) begin
        beat((i == 0) || (mid_sop && i == 3), {~cw[i], cw[i]}, i == 0 ? a : a_late);
        if (i == 0) check({req, " drop"}, cell_drop, !ok);
      end
    end else begin
      for (int j = 0; j < CELL/2; j++) begin
        beat((j == 0) || (mid_sop && j == 2), {cw[2*j+1], cw[2*j]}, j == 0 ? a : a_late);
        if (j == 0) begin
          check({req, " drop"}, cell_drop, !ok);
          check("R6 in_ready gap", in_ready, 0);
        end
      end
    end
  endtask

  task automatic drain;
    for (int n = 0; n < 3000; n++) begin
      if (expq[0].size() + expq[1].size() + expq[2].size() + expq[3].size() == 0) break;
      @(posedge clk);
    end
    repeat (4) @(posedge clk);
    #2;
    for (int q = 0; q < 4; q++) check($sformatf("R10 drained q%0d", q), expq[q].size(), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R1 actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk); #2;
    check("R1 valid in reset", out_valid, 0);
    check("R1 ready in reset", in_ready, 1);
    check("R1 drop in reset", cell_drop, 0);
    rst = 0;
    @(posedge clk); #2;
    check("R1 valid after reset", out_valid, 0);
    check("R1 drop after reset", cell_drop, 0);

    stall_on = 1;
    // R2: singlecast out-band to each queue
    for (int d = 0; d < 4; d++) begin
      mk(16 * d + 1);
      send_cell("R2", 5'(d), 5'(d), 4'(1 << d), 0);
    end
    // R3: out-of-range singlecast addresses
    mk(200); send_cell("R3", 5'd4, 5'd4, 4'b0000, 0);
    mk(210); send_cell("R3", 5'd17, 5'd1, 4'b0000, 0);
    // R4: multicast enables, bit 4 ignored, empty set
    cfg_mcast = 1;
    mk(300); send_cell("R4", 5'b10101, 5'b10101, 4'b0101, 0);
    mk(320); send_cell("R4", 5'b01111, 5'b01111, 4'b1111, 0);
    mk(340); send_cell("R4", 5'b10000, 5'b10000, 4'b0000, 0);
    // R5: in-band routing, sideband pin ignored
    cfg_inband = 1; cfg_mcast = 0;
    mk(400); cw[0] = 9'h1E3; send_cell("R5", 5'd0, 5'd0, 4'b1000, 0);
    mk(420); cw[0] = 9'h0E2; send_cell("R5", 5'd1, 5'd1, 4'b0100, 0);
    cfg_mcast = 1;
    mk(440); cw[0] = 9'h0A6; send_cell("R5", 5'd1, 5'd1, 4'b0110, 0);
    // R6: two words per beat
    cfg_inband = 0; cfg_mcast = 0; cfg_narrow = 0;
    mk(500); send_cell("R6", 5'd1, 5'd1, 4'b0010, 0);
    cfg_mcast = 1;
    mk(520); send_cell("R6", 5'b01001, 5'b01001, 4'b1001, 0);
    cfg_mcast = 0;
    mk(540); send_cell("R6 R11", 5'd2, 5'd0, 4'b0100, 1);
    // R7: destination changes mid-cell
    cfg_narrow = 1;
    mk(600); send_cell("R7", 5'd0, 5'd3, 4'b0001, 0);
    // R11: stray beat outside a cell, then in-cell sop
    beat(0, 18'h00155, 5'd2);
    check("R11 stray no drop", cell_drop, 0);
    mk(620); send_cell("R11", 5'd3, 5'd3, 4'b1000, 1);
    drain();

    // R8: admission against queue room
    hold_all = 1;
    repeat (2) @(posedge clk); #2;
    for (int c = 0; c < DEPTH / CELL; c++) begin
      mk(700 + c); send_cell("R8 fill", 5'd1, 5'd1, 4'b0010, 0);
    end
    mk(800); send_cell("R8 full", 5'd1, 5'd1, 4'b0010, 0);
    cfg_mcast = 1;
    mk(820); send_cell("R8 partial", 5'b00011, 5'b00011, 4'b0011, 0);
    @(posedge clk); #2;
    check("R8 q0 untouched", out_valid[0], 0);
    check("R8 drop one cycle", cell_drop, 0);
    mk(840); send_cell("R8 other", 5'b00001, 5'b00001, 4'b0001, 0);
    hold_all = 0; stall_on = 0;
    drain();

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule